// File: doc/BRIEF.md
# SDRAM Command and Timing Controller

This block sits on the host side of a four-bank synchronous DRAM with a 4-bit data bus. It accepts one read or write request at a time, each with its own bank, row and column. It turns each request into DRAM commands on the chip-select, row-strobe, column-strobe, write-enable, clock-enable, bank and multiplexed address pins. It spaces those commands so that the device's minimum delays are met.

After reset the controller runs the power-up sequence. It drives only no-operation cycles for the settling period, then precharges every bank, issues two auto-refresh commands and programs the mode register. Only then does it accept requests. In normal operation each request opens its row, performs a single-beat access and closes the row again. A timer derived from the clock frequency inserts an auto-refresh at a fixed interval. Read data comes back a programmed CAS latency after the read command.

Top module: `sdram_ctl`

## Requirements
- R1: While reset is asserted, clock enable is low, chip select is high, the data mask is high, `init_done` is low, `req_ready` is low and the data output enable is low.
- R2: After reset, no command (chip select low) appears for at least INIT_CYC clocks (10000 at 50 MHz). Clock enable is high in the clock before every command.
- R3: Power-up runs in this order: precharge-all (A10 high), auto-refresh, auto-refresh, mode-register-set. The mode word is CAS latency in A6:A4, burst length 1 (A2:A0 = 000) and sequential order (A3 = 0), so CAS latency 2 gives 12'h020. No request is accepted before `init_done` rises.
- R4: Commands use chip select low and {RAS#,CAS#,WE#} codes: activate 011, read 101, write 100, precharge 010, auto-refresh 001, mode-register-set 000. Idle cycles use chip select high.
- R5: Activate drives the bank on BA and the 12-bit row on A11:A0. Read and write drive the bank on BA, column bits 9:0 on A9:A0 and column bit 10 on A11, with A10 low (no auto-precharge).
- R6: Read or write follows activate of the same bank by at least the row-to-column delay (1 clock at 50 MHz). Each access is followed by a precharge of that bank (A10 low) before the next activate.
- R7: Precharge comes no earlier than 2 clocks after a write. The next activate comes no earlier than 2 clocks plus the precharge time (3 clocks at 50 MHz) after a write.
- R8: Write data appears on the data output with output enable high and data mask low in the write command cycle only.
- R9: Read data present on the data input CAS_LAT clocks after the read command is returned on `rd_data` with a one-cycle `rd_valid` pulse.
- R10: After initialisation, an auto-refresh is issued at least every REFI_CYC clocks (781 at 50 MHz) plus the length of an access already in progress. The next activate waits the refresh cycle time (4 clocks at 50 MHz).
- R11: `req_ready` is high for exactly the one cycle in which a request is taken; it stays low on the following cycle even if `req_valid` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Request bank |
| req_row | input | 12 | Request row |
| req_col | input | 11 | Request column |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Request taken this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| init_done | output | 1 | Power-up sequence finished |
| sd_cke | output | 1 | DRAM clock enable |
| sd_cs_n | output | 1 | DRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 4 | Data to DRAM |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 4 | Data from DRAM |

## Verification
The request path is driven with writes and reads that differ only in bank, only in row, or only in column bit 10. A read returning the wrong nibble shows a lost bank, row or high-column bit in the address multiplexing. The table writes back-to-back to the same bank and then reads back to back, which tests write recovery and row-to-column spacing against a DRAM model that times every command. A request held high through power-up, and long idle stretches, show whether requests are gated correctly and refresh stays on schedule.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {RAS#, CAS#, WE#} with chip select low
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sdc_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_REF1,
    ST_REF2,
    ST_MODE,
    ST_IDLE,
    ST_ACCESS,
    ST_CLOSE
  } sdc_state_e;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int REFI_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(REFI_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = en && (cnt_q == CW'(REFI_CYC - 1));

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (en) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (wrap)     pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // age of an outstanding refresh, for the bound check
  logic [6:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (!pend_q) age_q <= '0;
    else if (age_q != 7'h7f) age_q <= age_q + 1'b1;
  end

  assert_refresh_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (age_q < 7'd40));

  assert_ack_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend_q);

endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
  parameter int CAS_LAT = 2,
  parameter int DATA_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] pipe_q;
  logic               vld_q;
  logic [DATA_W-1:0]  dat_q;

  generate
    for (genvar i = 0; i < CAS_LAT; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= rd_issue;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= pipe_q[CAS_LAT-1];
      if (pipe_q[CAS_LAT-1]) dat_q <= dq_in;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = dat_q;

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(rd_issue, CAS_LAT + 1));

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 11,
  parameter int INIT_CYC  = 10000,
  parameter int RCD_CYC   = 1,
  parameter int RP_CYC    = 1,
  parameter int RC_CYC    = 4,
  parameter int MRD_CYC   = 2,
  parameter int TWR_CYC   = 2,
  parameter int RD2PRE    = 2,
  parameter int WR2PRE    = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic              req_accept,
  output logic              init_done,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              dqm,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rd_issue
);
  localparam int WAIT_W = $clog2(INIT_CYC + 1);
  localparam int AP_BIT = 10;

  sdc_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  sdc_cmd_e          cmd_q, cmd_d;
  logic              cs_n_q, cs_n_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0] dq_out_q, dq_out_d;
  logic              dq_oe_q, dq_oe_d;
  logic              init_q, init_d;
  logic              cke_q, dqm_q;
  logic [COL_W-1:0]  col_q, col_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d    = state_q;
    wait_d     = (wait_q != '0) ? wait_q - 1'b1 : wait_q;
    cmd_d      = CMD_NOP;
    cs_n_d     = 1'b1;
    ba_d       = ba_q;
    addr_d     = addr_q;
    dq_out_d   = dq_out_q;
    dq_oe_d    = 1'b0;
    init_d     = init_q;
    col_d      = col_q;
    wr_d       = wr_q;
    wdata_d    = wdata_q;
    req_accept = 1'b0;
    ref_ack    = 1'b0;
    if (wait_q == '0) begin
      unique case (state_q)
        ST_POWER: begin
          cmd_d          = CMD_PRE;
          cs_n_d         = 1'b0;
          addr_d         = '0;
          addr_d[AP_BIT] = 1'b1;
          wait_d         = WAIT_W'(RP_CYC - 1);
          state_d        = ST_REF1;
        end
        ST_REF1, ST_REF2: begin
          cmd_d   = CMD_REF;
          cs_n_d  = 1'b0;
          wait_d  = WAIT_W'(RC_CYC - 1);
          state_d = (state_q == ST_REF1) ? ST_REF2 : ST_MODE;
        end
        ST_MODE: begin
          cmd_d   = CMD_MRS;
          cs_n_d  = 1'b0;
          ba_d    = '0;
          addr_d  = MODE_WORD;
          wait_d  = WAIT_W'(MRD_CYC - 1);
          init_d  = 1'b1;
          state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_d   = CMD_REF;
            cs_n_d  = 1'b0;
            wait_d  = WAIT_W'(RC_CYC - 1);
            ref_ack = 1'b1;
          end else if (req_valid) begin
            cmd_d      = CMD_ACT;
            cs_n_d     = 1'b0;
            ba_d       = req_bank;
            addr_d     = req_row;
            col_d      = req_col;
            wr_d       = req_write;
            wdata_d    = req_wdata;
            req_accept = 1'b1;
            wait_d     = WAIT_W'(RCD_CYC - 1);
            state_d    = ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          cmd_d   = wr_q ? CMD_WR : CMD_RD;
          cs_n_d  = 1'b0;
          addr_d  = {col_q[10], 1'b0, col_q[9:0]};
          if (wr_q) begin
            dq_oe_d  = 1'b1;
            dq_out_d = wdata_q;
            wait_d   = WAIT_W'(WR2PRE - 1);
          end else begin
            wait_d   = WAIT_W'(RD2PRE - 1);
          end
          state_d = ST_CLOSE;
        end
        ST_CLOSE: begin
          cmd_d          = CMD_PRE;
          cs_n_d         = 1'b0;
          addr_d[AP_BIT] = 1'b0;
          wait_d         = WAIT_W'(RP_CYC - 1);
          state_d        = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_POWER;
      wait_q   <= WAIT_W'(INIT_CYC - 1);
      cmd_q    <= CMD_NOP;
      cs_n_q   <= 1'b1;
      ba_q     <= '0;
      addr_q   <= '0;
      dq_out_q <= '0;
      dq_oe_q  <= 1'b0;
      init_q   <= 1'b0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      wait_q   <= wait_d;
      cmd_q    <= cmd_d;
      cs_n_q   <= cs_n_d;
      ba_q     <= ba_d;
      addr_q   <= addr_d;
      dq_out_q <= dq_out_d;
      dq_oe_q  <= dq_oe_d;
      init_q   <= init_d;
      col_q    <= col_d;
      wr_q     <= wr_d;
      wdata_q  <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dqm_q <= 1'b1;
    else if (init_q) dqm_q <= 1'b0;
  end

  assign init_done = init_q;
  assign cke       = cke_q;
  assign cs_n      = cs_n_q;
  assign {ras_n, cas_n, we_n} = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign dqm       = dqm_q;
  assign dq_out    = dq_out_q;
  assign dq_oe     = dq_oe_q;
  assign rd_issue  = !cs_n_q && (cmd_q == CMD_RD);

  // Spacing observers, counting clocks since commands appeared on the pins
  logic [5:0] since_act_q, since_wr_q;
  logic       on_act, on_wr;
  assign on_act = !cs_n_q && (cmd_q == CMD_ACT);
  assign on_wr  = !cs_n_q && (cmd_q == CMD_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_q <= '1;
      since_wr_q  <= '1;
    end else begin
      since_act_q <= on_act ? 6'd1 : ((since_act_q == '1) ? since_act_q : since_act_q + 1'b1);
      since_wr_q  <= on_wr  ? 6'd1 : ((since_wr_q  == '1) ? since_wr_q  : since_wr_q  + 1'b1);
    end
  end

  assert_cke_before_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> $past(cke_q));

  assert_act_after_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    on_act |-> init_q);

  assert_rcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && (cmd_q == CMD_RD || cmd_q == CMD_WR)) |-> (since_act_q >= 6'(RCD_CYC)));

  assert_wr_to_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && cmd_q == CMD_PRE) |-> (since_wr_q >= 6'(TWR_CYC)));

  assert_wr_to_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    on_act |-> (since_wr_q >= 6'(TWR_CYC + RP_CYC)));

  assert_oe_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> (on_wr && !dqm_q));

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !req_accept);

endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
  import sdc_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int CAS_LAT    = 2,
  parameter int DATA_W     = 4,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 11,
  parameter int T_INIT_US  = 200,
  parameter int T_REFI_NS  = 15625,
  parameter int T_RCD_NS   = 20,
  parameter int T_RP_NS    = 20,
  parameter int T_RAS_NS   = 50,
  parameter int T_RC_NS    = 70,
  parameter int TWR_CYC    = 2,
  parameter int MRD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int INIT_CYC = T_INIT_US * CLK_MHZ;
  localparam int REFI_CYC = (T_REFI_NS * CLK_MHZ) / 1000;
  localparam int RCD_CYC  = ns_to_cyc(T_RCD_NS, CLK_MHZ);
  localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_MHZ);
  localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_MHZ);
  localparam int RAS_REM  = (RAS_CYC > RCD_CYC) ? RAS_CYC - RCD_CYC : 1;
  localparam int RD2PRE   = RAS_REM;
  localparam int WR2PRE   = (RAS_REM > TWR_CYC) ? RAS_REM : TWR_CYC;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic ref_pend, ref_ack, rd_issue;

  sdc_refresh_timer #(
    .REFI_CYC (REFI_CYC)
  ) u_refresh (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (init_done),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  sdc_sequencer #(
    .DATA_W    (DATA_W),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .INIT_CYC  (INIT_CYC),
    .RCD_CYC   (RCD_CYC),
    .RP_CYC    (RP_CYC),
    .RC_CYC    (RC_CYC),
    .MRD_CYC   (MRD_CYC),
    .TWR_CYC   (TWR_CYC),
    .RD2PRE    (RD2PRE),
    .WR2PRE    (WR2PRE),
    .MODE_WORD (MODE_WORD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bank   (req_bank),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_wdata  (req_wdata),
    .ref_pend   (ref_pend),
    .ref_ack    (ref_ack),
    .req_accept (req_ready),
    .init_done  (init_done),
    .cke        (sd_cke),
    .cs_n       (sd_cs_n),
    .ras_n      (sd_ras_n),
    .cas_n      (sd_cas_n),
    .we_n       (sd_we_n),
    .ba         (sd_ba),
    .addr       (sd_addr),
    .dqm        (sd_dqm),
    .dq_out     (sd_dq_out),
    .dq_oe      (sd_dq_oe),
    .rd_issue   (rd_issue)
  );

  sdc_read_capture #(
    .CAS_LAT (CAS_LAT),
    .DATA_W  (DATA_W)
  ) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_issue (rd_issue),
    .dq_in    (sd_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/sim_sdram_ctl.sv
`timescale 1ns/1ps
module sim_sdram_ctl;
  localparam int INIT_EXP = 10000;
  localparam int RCD_EXP  = 1;
  localparam int RP_EXP   = 1;
  localparam int RC_EXP   = 4;
  localparam int TWR_EXP  = 2;
  localparam int REFI_EXP = 781;
  localparam int CL_EXP   = 2;
  localparam int NVEC     = 12;

  // {write, bank[1:0], row[11:0], col[10:0], data[3:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 12'h005, 11'h003, 4'hA},
    {1'b1, 2'd1, 12'h005, 11'h003, 4'h5},
    {1'b1, 2'd0, 12'h005, 11'h403, 4'hC},
    {1'b1, 2'd2, 12'h001, 11'h001, 4'h3},
    {1'b1, 2'd2, 12'h002, 11'h001, 4'h6},
    {1'b1, 2'd3, 12'hFFF, 11'h7FF, 4'h9},
    {1'b0, 2'd0, 12'h005, 11'h003, 4'hA},
    {1'b0, 2'd1, 12'h005, 11'h003, 4'h5},
    {1'b0, 2'd0, 12'h005, 11'h403, 4'hC},
    {1'b0, 2'd2, 12'h001, 11'h001, 4'h3},
    {1'b0, 2'd2, 12'h002, 11'h001, 4'h6},
    {1'b0, 2'd3, 12'hFFF, 11'h7FF, 4'h9}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [10:0] req_col;
  logic [3:0]  req_wdata;
  logic        req_ready, rd_valid, init_done;
  logic [3:0]  rd_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dq_out, sd_dq_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sdram_ctl u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_bank (req_bank),
    .req_row (req_row), .req_col (req_col), .req_wdata (req_wdata),
    .req_ready (req_ready), .rd_valid (rd_valid), .rd_data (rd_data),
    .init_done (init_done),
    .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
    .sd_addr (sd_addr), .sd_dqm (sd_dqm), .sd_dq_out (sd_dq_out),
    .sd_dq_oe (sd_dq_oe), .sd_dq_in (sd_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [3:0] mem [512];
  int  cyc = 0, n_cmd = 0, ref_cnt = 0;
  int  last_act = -100, last_wr = -100, last_pre = -100, last_ref = -100;
  bit  row_open = 0, prev_cke = 0;
  logic [1:0]  open_bank;
  logic [11:0] open_row;
  int  rd_left = 0;
  logic [3:0] rd_val;

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 4'h0;
    sd_dq_in = 4'h0;
    open_bank = 2'd0;
    open_row  = 12'd0;
    rd_val    = 4'h0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; prev_cke = 0;
    end else begin
      logic [2:0] c;
      logic [10:0] col;
      logic [8:0]  idx;
      cyc++;
      if (rd_left > 0) begin
        rd_left--;
        if (rd_left == 0) sd_dq_in <= rd_val;
      end
      c   = {sd_ras_n, sd_cas_n, sd_we_n};
      col = {sd_addr[11], sd_addr[9:0]};
      if (sd_dq_oe)
        check(!sd_cs_n && c == 3'b100 && !sd_dqm, "R8", "oe outside write", int'(c), 4);
      if (!sd_cs_n) begin
        check(prev_cke, "R2", "cke before command", 0, 1);
        if (n_cmd == 0) begin
          check(c == 3'b010 && sd_addr[10], "R3", "first cmd precharge-all", int'(c), 2);
          check(cyc >= INIT_EXP, "R2", "power-up wait", cyc, INIT_EXP);
        end else if (n_cmd == 1 || n_cmd == 2) begin
          check(c == 3'b001, "R3", "init refresh", int'(c), 1);
          last_ref = cyc;
        end else if (n_cmd == 3) begin
          check(c == 3'b000, "R3", "mode set", int'(c), 0);
          check(sd_addr == 12'h020, "R3", "mode word", int'(sd_addr), 12'h020);
        end else begin
          case (c)
            3'b011: begin
              check(!row_open, "R6", "activate with row open", 1, 0);
              check(cyc - last_wr >= TWR_EXP + RP_EXP, "R7", "write to activate", cyc - last_wr, TWR_EXP + RP_EXP);
              check(cyc - last_pre >= RP_EXP, "R6", "precharge to activate", cyc - last_pre, RP_EXP);
              check(cyc - last_ref >= RC_EXP, "R10", "refresh to activate", cyc - last_ref, RC_EXP);
              row_open = 1; open_bank = sd_ba; open_row = sd_addr; last_act = cyc;
            end
            3'b101, 3'b100: begin
              check(row_open && sd_ba == open_bank, "R5", "access bank", int'(sd_ba), int'(open_bank));
              check(!sd_addr[10], "R5", "A10 low on access", 1, 0);
              check(cyc - last_act >= RCD_EXP, "R6", "act to access", cyc - last_act, RCD_EXP);
              idx = {sd_ba, open_row[2:0], col[10], col[2:0]};
              if (c == 3'b100) begin
                check(sd_dq_oe && !sd_dqm, "R8", "write data enable", int'(sd_dq_oe), 1);
                if (!sd_dqm) mem[idx] = sd_dq_out;
                last_wr = cyc;
              end else begin
                rd_val  = mem[idx];
                rd_left = CL_EXP - 1;
              end
            end
            3'b010: begin
              check(!sd_addr[10] && row_open && sd_ba == open_bank, "R6", "precharge bank", int'(sd_ba), int'(open_bank));
              check(cyc - last_wr >= TWR_EXP, "R7", "write recovery", cyc - last_wr, TWR_EXP);
              row_open = 0; last_pre = cyc;
            end
            3'b001: begin
              check(!row_open, "R10", "refresh with row open", 1, 0);
              check(cyc - last_ref <= REFI_EXP + 40, "R10", "refresh interval", cyc - last_ref, REFI_EXP);
              last_ref = cyc; ref_cnt++;
            end
            default: check(0, "R4", "illegal command code", int'(c), 7);
          endcase
        end
        n_cmd++;
      end
      if (n_cmd > 3 && cyc - last_ref > REFI_EXP + 40 && !done) begin
        check(0, "R10", "refresh overdue", cyc - last_ref, REFI_EXP);
        last_ref = cyc;
      end
      prev_cke = sd_cke;
    end
  end

  // requests must not be taken before initialisation ends
  bit early_take = 0;
  always @(negedge clk) if (rst_n && req_ready && !init_done) early_take = 1;

  task automatic do_req(input logic [29:0] v, input string tag);
    int n;
    @(negedge clk);
    req_write = v[29]; req_bank = v[28:27]; req_row = v[26:15];
    req_col = v[14:4]; req_wdata = v[3:0]; req_valid = 1'b1;
    n = 0;
    #1;
    while (!req_ready && n < 20000) begin
      @(negedge clk); #1; n++;
    end
    check(req_ready, "R11", {tag, " request taken"}, int'(req_ready), 1);
    @(negedge clk);
    check(!req_ready, "R11", {tag, " ready one cycle"}, int'(req_ready), 0);
    req_valid = 1'b0;
    if (!v[29]) begin
      n = 0;
      while (!rd_valid && n < 30) begin
        @(negedge clk); n++;
      end
      check(rd_valid, "R9", {tag, " read returned"}, int'(rd_valid), 1);
      check(rd_data == v[3:0], "R9", {tag, " read data (R5 mapping)"}, int'(rd_data), int'(v[3:0]));
      @(negedge clk);
      check(!rd_valid, "R9", {tag, " valid pulse"}, int'(rd_valid), 0);
    end
  endtask

  initial begin
    int r0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
    req_row = '0; req_col = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!sd_cke, "R1", "cke in reset", int'(sd_cke), 0);
    check(sd_cs_n, "R1", "cs_n in reset", int'(sd_cs_n), 1);
    check(sd_dqm, "R1", "dqm in reset", int'(sd_dqm), 1);
    check(!init_done, "R1", "init_done in reset", int'(init_done), 0);
    check(!req_ready && !sd_dq_oe, "R1", "ready/oe in reset", int'(req_ready), 0);
    // hold a write request through power-up
    req_write = 1'b1; req_bank = 2'd2; req_row = 12'h007;
    req_col = 11'h007; req_wdata = 4'hF; req_valid = 1'b1;
    rst_n = 1'b1;
    do_req({1'b1, 2'd2, 12'h007, 11'h007, 4'hF}, "R3 held");
    check(!early_take, "R3", "no take before init_done", int'(early_take), 0);
    check(init_done, "R3", "init_done after sequence", int'(init_done), 1);

    for (int i = 0; i < NVEC; i++) do_req(VEC[i], "table");

    do_req({1'b0, 2'd2, 12'h007, 11'h007, 4'hF}, "R3 held readback");

    // R10: idle refresh schedule
    r0 = ref_cnt;
    repeat (2000) @(negedge clk);
    check(ref_cnt - r0 >= 2, "R10", "refreshes during idle", ref_cnt - r0, 2);

    // write then read, requests offered back to back around refresh
    do_req({1'b1, 2'd1, 12'h003, 11'h402, 4'h7}, "R7 b2b");
    do_req({1'b0, 2'd1, 12'h003, 11'h402, 4'h7}, "R7 b2b");
    check(sd_cs_n || {sd_ras_n, sd_cas_n, sd_we_n} != 3'b111, "R4", "cs low only with command", 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule